// File: doc/BRIEF.md
# Two-Format 16-bit Accumulator Processor Core

This block is a single-cycle processor core. Every clock it takes one 16-bit instruction word from an external instruction store and executes it completely. It holds two data registers inside the core, an address register A and a data register D. It also holds a 15-bit fetch counter. The data memory sits outside the core. The core reads it through `mem_rdata` and writes it through `mem_we` and `mem_wdata`, and the address of that memory operand is always the current contents of A.

Bit 15 of the instruction picks one of two formats. A word with bit 15 clear is a load-address word. It places its 15-bit payload into A. A word with bit 15 set is a compute word. It carries six ALU control bits, an operand-select bit, three destination bits and three branch-condition bits. The ALU always takes D on its x side. On its y side it takes either A or the memory operand. The result can go to A, to D and to memory, in any combination. The fetch counter then steps by one or branches to the address in A.

Two small enumerated decisions steer the core. The decoder classifies each word as `FMT_LOAD_A` or `FMT_COMPUTE`. The sequencer picks the next fetch address from three choices:
- `NXT_RESET` forces zero.
- `NXT_BRANCH` takes A.
- `NXT_STEP` increments the counter.

They are listed in falling priority.

Top module: `acc16_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, `fetch_addr` becomes 0 on that edge. This holds even when the instruction word would branch.
- R2: A word with bit 15 = 0 loads bits 14:0, zero-extended, into A. The new value is visible on `mem_addr` after the edge.
- R3: A word with bit 15 = 0 never asserts `mem_we` and never branches, so `fetch_addr` increments by one.
- R4: In a compute word, bit 12 selects the ALU y operand: 0 takes A and 1 takes `mem_rdata`. The x operand is always D.
- R5: Compute bits 11..6 act in this order: zero x, invert x, zero y, invert y, function (1 = add, 0 = bitwise AND), invert result. The result is 16 bits modulo 2^16.
- R6: Compute bit 5 writes the result into A and bit 4 writes it into D. Bit 3 raises `mem_we` in the same cycle, with `mem_wdata` equal to the result and `mem_addr` equal to A.
- R7: Compute bit 2 branches if the result is negative (bit 15 set), bit 1 if it is zero, and bit 0 if it is positive and nonzero. Any satisfied condition loads `fetch_addr` with A[14:0]; otherwise it increments.
- R8: Branch bits 111 always branch and branch bits 000 never branch.
- R9: Bits 14 and 13 of a compute word have no effect on the result, the writes or the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the fetch counter |
| instr | input | 16 | Instruction word at the current fetch address |
| mem_rdata | input | 16 | Data memory word at `mem_addr` |
| mem_wdata | output | 16 | ALU result, the value to write to memory |
| mem_we | output | 1 | Data memory write enable |
| mem_addr | output | 15 | Data memory address, the low bits of A |
| fetch_addr | output | 15 | Address of the instruction to execute |

## Verification
On every cycle the embedded properties check several behaviours. Reset forces the fetch address to zero. Load-address words never write memory and never branch, and they leave their payload on the memory address. A result written to A reappears as the next memory address. Unconditional and never-branch codes go where they must. Only the directed scenarios can show that each ALU control combination gives the right value and that the operand-select bit really picks memory over A. They also show that each single condition bit and mixed condition masks branch on the right sign and zero cases, and that the two ignored bits change nothing.

// File: rtl/acc16_pkg.sv
package acc16_pkg;

    localparam int WORD_W = 16;

    typedef enum logic {
        FMT_LOAD_A,
        FMT_COMPUTE
    } fmt_e;

    typedef enum logic [1:0] {
        NXT_RESET,
        NXT_BRANCH,
        NXT_STEP
    } nxt_e;

    typedef struct packed {
        logic zero_x;
        logic inv_x;
        logic zero_y;
        logic inv_y;
        logic use_add;
        logic inv_res;
    } alu_ctl_t;

    typedef struct packed {
        fmt_e     fmt;
        logic     y_from_mem;
        alu_ctl_t ctl;
        logic     wr_a;
        logic     wr_d;
        logic     wr_mem;
        logic     br_neg;
        logic     br_zero;
        logic     br_pos;
    } decoded_t;

endpackage

// File: rtl/acc16_alu.sv
module acc16_alu
    import acc16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  alu_ctl_t     ctl,
    output logic [W-1:0] res,
    output logic         is_zero,
    output logic         is_neg
);
    localparam int N_OPS = 2;

    logic [W-1:0] raw  [N_OPS];
    logic [W-1:0] pre  [N_OPS];
    logic [N_OPS-1:0] zap;
    logic [N_OPS-1:0] flip;
    logic [W-1:0] core;

    assign raw[0] = x_in;
    assign raw[1] = y_in;
    assign zap    = {ctl.zero_y, ctl.zero_x};
    assign flip   = {ctl.inv_y,  ctl.inv_x};

    // identical preset stage for each operand
    for (genvar g = 0; g < N_OPS; g++) begin : g_preset
        assign pre[g] = (zap[g] ? '0 : raw[g]) ^ {W{flip[g]}};
    end

    always_comb begin
        core    = ctl.use_add ? (pre[0] + pre[1]) : (pre[0] & pre[1]);
        res     = ctl.inv_res ? ~core : core;
        is_zero = (res == '0);
        is_neg  = res[W-1];
    end
endmodule

// File: rtl/acc16_decode.sv
module acc16_decode
    import acc16_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output decoded_t          dec,
    output logic [WORD_W-1:0] imm
);
    logic [1:0] unused_fill;
    fmt_e       kind;

    assign unused_fill = instr[14:13];
    assign kind        = instr[15] ? FMT_COMPUTE : FMT_LOAD_A;
    assign imm         = {1'b0, instr[WORD_W-2:0]};

    always_comb begin
        dec     = '0;
        dec.fmt = kind;
        unique case (kind)
            FMT_LOAD_A: begin
                dec.fmt = FMT_LOAD_A;
            end
            FMT_COMPUTE: begin
                dec.y_from_mem = instr[12];
                dec.ctl        = alu_ctl_t'(instr[11:6]);
                dec.wr_a       = instr[5];
                dec.wr_d       = instr[4];
                dec.wr_mem     = instr[3];
                dec.br_neg     = instr[2];
                dec.br_zero    = instr[1];
                dec.br_pos     = instr[0];
            end
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/acc16_seq.sv
module acc16_seq
    import acc16_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          is_compute,
    input  logic [2:0]    br_mask,
    input  logic          res_zero,
    input  logic          res_neg,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);
    nxt_e          sel;
    logic          cond_hit;
    logic [AW-1:0] pc_next;

    always_comb begin
        cond_hit = (br_mask[2] & res_neg) |
                   (br_mask[1] & res_zero) |
                   (br_mask[0] & ~res_neg & ~res_zero);
        if (rst)
            sel = NXT_RESET;
        else if (is_compute && cond_hit)
            sel = NXT_BRANCH;
        else
            sel = NXT_STEP;
    end

    always_comb begin
        unique case (sel)
            NXT_RESET:  pc_next = '0;
            NXT_BRANCH: pc_next = target;
            NXT_STEP:   pc_next = pc + 1'b1;
            default:    pc_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        pc <= pc_next;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (pc == '0));

    assert_always_branch_R8: assert property (@(posedge clk) disable iff (rst)
        (is_compute && br_mask == 3'b111) |=> (pc == $past(target)));

    assert_never_branch_R8: assert property (@(posedge clk) disable iff (rst)
        (br_mask == 3'b000) |=> (pc == $past(pc) + 1'b1));
endmodule

// File: rtl/acc16_core.sv
module acc16_core
    import acc16_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [DATA_W-2:0] mem_addr,
    output logic [DATA_W-2:0] fetch_addr
);
    localparam int ADDR_W = DATA_W - 1;

    decoded_t          dec;
    logic [DATA_W-1:0] imm;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    logic [DATA_W-1:0] y_op;
    logic [DATA_W-1:0] alu_res;
    logic              alu_zero;
    logic              alu_neg;

    acc16_decode u_dec (
        .instr (instr),
        .dec   (dec),
        .imm   (imm)
    );

    assign y_op = dec.y_from_mem ? mem_rdata : a_q;

    acc16_alu #(.W(DATA_W)) u_alu (
        .x_in    (d_q),
        .y_in    (y_op),
        .ctl     (dec.ctl),
        .res     (alu_res),
        .is_zero (alu_zero),
        .is_neg  (alu_neg)
    );

    always_ff @(posedge clk) begin
        if (dec.fmt == FMT_LOAD_A)
            a_q <= imm;
        else if (dec.wr_a)
            a_q <= alu_res;
        if (dec.wr_d)
            d_q <= alu_res;
    end

    acc16_seq #(.AW(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .is_compute (dec.fmt == FMT_COMPUTE),
        .br_mask    ({dec.br_neg, dec.br_zero, dec.br_pos}),
        .res_zero   (alu_zero),
        .res_neg    (alu_neg),
        .target     (a_q[ADDR_W-1:0]),
        .pc         (fetch_addr)
    );

    assign mem_wdata = alu_res;
    assign mem_we    = dec.wr_mem;
    assign mem_addr  = a_q[ADDR_W-1:0];

    assert_load_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        !instr[DATA_W-1] |-> !mem_we);

    assert_load_steps_R3: assert property (@(posedge clk) disable iff (rst)
        !instr[DATA_W-1] |=> (fetch_addr == $past(fetch_addr) + 1'b1));

    assert_load_payload_R2: assert property (@(posedge clk) disable iff (rst)
        !instr[DATA_W-1] |=> (mem_addr == $past(instr[ADDR_W-1:0])));

    assert_result_to_a_R6: assert property (@(posedge clk) disable iff (rst)
        (instr[DATA_W-1] && instr[5]) |=> (mem_addr == $past(mem_wdata[ADDR_W-1:0])));
endmodule

// File: tb/sim_acc16_core.sv
module sim_acc16_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = 16'h0000;
    logic [15:0] mem_rdata = 16'h0000;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [14:0] mem_addr;
    logic [14:0] fetch_addr;

    int n_chk = 0;
    int n_err = 0;
    logic [14:0] pcx = '0;
    bit finished = 1'b0;

    localparam logic [5:0] OP_ZERO  = 6'b101010;
    localparam logic [5:0] OP_ONE   = 6'b111111;
    localparam logic [5:0] OP_MONE  = 6'b111010;
    localparam logic [5:0] OP_D     = 6'b001100;
    localparam logic [5:0] OP_Y     = 6'b110000;
    localparam logic [5:0] OP_NOTD  = 6'b001101;
    localparam logic [5:0] OP_DPY   = 6'b000010;
    localparam logic [5:0] OP_DMY   = 6'b010011;
    localparam logic [5:0] OP_YMD   = 6'b000111;
    localparam logic [5:0] OP_DANDY = 6'b000000;
    localparam logic [5:0] OP_DORY  = 6'b010101;

    always #2 clk = ~clk;

    acc16_core u0 (
        .clk        (clk),
        .rst        (rst),
        .instr      (instr),
        .mem_rdata  (mem_rdata),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .fetch_addr (fetch_addr)
    );

    function automatic logic [15:0] cw(input logic a, input logic [5:0] op,
                                       input logic [2:0] dst, input logic [2:0] br);
        return {3'b111, a, op, dst, br};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [15:0] ins, input logic [15:0] rd);
        @(negedge clk);
        rst = 1'b0;
        instr = ins;
        mem_rdata = rd;
        #1;
    endtask

    task automatic commit(input bit taken, input logic [14:0] tgt, input string req);
        @(posedge clk);
        #1;
        pcx = taken ? tgt : pcx + 15'd1;
        chk(req, {1'b0, fetch_addr}, {1'b0, pcx});
    endtask

    task automatic run(input logic [15:0] ins, input string req);
        setup(ins, 16'h0000);
        commit(1'b0, 15'd0, req);
    endtask

    // R1: reset holds fetch address at zero even under an always-branch word
    task automatic t_reset;
        rst = 1'b1;
        instr = cw(1'b0, OP_ZERO, 3'b000, 3'b111);
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset pc", {1'b0, fetch_addr}, 16'h0000);
        @(posedge clk);
        #1;
        chk("R1 reset beats branch", {1'b0, fetch_addr}, 16'h0000);
        pcx = '0;
    endtask

    // R2, R3: load-address words
    task automatic t_load;
        setup(16'h1234, 16'h0000);
        chk("R3 no write on load word", {15'd0, mem_we}, 16'h0000);
        commit(1'b0, 15'd0, "R3 load word steps");
        chk("R2 payload on mem_addr", {1'b0, mem_addr}, 16'h1234);
        setup(16'h7FFF, 16'h0000);
        commit(1'b0, 15'd0, "R3 load word steps");
        chk("R2 max payload", {1'b0, mem_addr}, 16'h7FFF);
    endtask

    // R5, R6: ALU functions with D=5, A=3, observed on the memory write port
    task automatic t_alu;
        logic [5:0]  ops [11];
        logic [15:0] exps[11];
        ops = '{OP_ZERO, OP_ONE, OP_MONE, OP_D, OP_Y, OP_NOTD, OP_DPY,
                OP_DMY, OP_YMD, OP_DANDY, OP_DORY};
        exps = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0005, 16'h0003, 16'hFFFA,
                 16'h0008, 16'h0002, 16'hFFFE, 16'h0001, 16'h0007};
        run(16'd5, "R2 set A");
        run(cw(1'b0, OP_Y, 3'b010, 3'b000), "R6 copy A to D");
        run(16'd3, "R2 set A");
        for (int i = 0; i < 11; i++) begin
            setup(cw(1'b0, ops[i], 3'b001, 3'b000), 16'h0000);
            chk("R6 write enable", {15'd0, mem_we}, 16'h0001);
            chk("R6 write address is A", {1'b0, mem_addr}, 16'h0003);
            chk("R5 alu result", mem_wdata, exps[i]);
            commit(1'b0, 15'd0, "R7 no branch bits");
        end
    endtask

    // R4: operand select picks memory over A
    task automatic t_ysel;
        setup(cw(1'b1, OP_DPY, 3'b001, 3'b000), 16'd100);
        chk("R4 y from memory", mem_wdata, 16'd105);
        commit(1'b0, 15'd0, "R4 step");
        setup(cw(1'b0, OP_DPY, 3'b001, 3'b000), 16'd100);
        chk("R4 y from A", mem_wdata, 16'd8);
        commit(1'b0, 15'd0, "R4 step");
    endtask

    // R9: bits 14:13 ignored
    task automatic t_ignored;
        setup({3'b100, 1'b0, OP_DMY, 3'b001, 3'b000}, 16'h0000);
        chk("R9 ignored bits result", mem_wdata, 16'h0002);
        chk("R9 ignored bits write", {15'd0, mem_we}, 16'h0001);
        commit(1'b0, 15'd0, "R9 ignored bits step");
    endtask

    // R6: result into A becomes the next memory address; D only via bit 4
    task automatic t_dest;
        run(cw(1'b0, 6'b011111, 3'b100, 3'b000), "R6 A=D+1");
        chk("R6 result into A", {1'b0, mem_addr}, 16'h0006);
        setup(cw(1'b0, OP_D, 3'b001, 3'b000), 16'h0000);
        chk("R6 D unchanged by A write", mem_wdata, 16'h0005);
        commit(1'b0, 15'd0, "R6 step");
    endtask

    // R7, R8: branch conditions
    task automatic t_branch;
        run(16'd40, "R2 target");
        run(cw(1'b0, OP_ZERO, 3'b010, 3'b000), "R6 D=0");
        setup(cw(1'b0, OP_D, 3'b000, 3'b010), 16'h0000);
        commit(1'b1, 15'd40, "R7 branch on zero");
        run(16'd5, "R2 set A");
        run(cw(1'b0, OP_Y, 3'b010, 3'b000), "R6 D=5");
        run(16'd60, "R2 target");
        setup(cw(1'b0, OP_D, 3'b000, 3'b100), 16'h0000);
        commit(1'b0, 15'd0, "R7 positive not negative");
        setup(cw(1'b0, OP_D, 3'b000, 3'b001), 16'h0000);
        commit(1'b1, 15'd60, "R7 branch on positive");
        run(cw(1'b0, OP_MONE, 3'b010, 3'b000), "R6 D=-1");
        setup(cw(1'b0, OP_D, 3'b000, 3'b011), 16'h0000);
        commit(1'b0, 15'd0, "R7 negative fails zero|pos");
        setup(cw(1'b0, OP_D, 3'b000, 3'b100), 16'h0000);
        commit(1'b1, 15'd60, "R7 branch on negative");
        setup(cw(1'b0, OP_D, 3'b000, 3'b000), 16'h0000);
        commit(1'b0, 15'd0, "R8 never branch");
        setup(cw(1'b0, OP_ONE, 3'b000, 3'b111), 16'h0000);
        commit(1'b1, 15'd60, "R8 always branch");
        run(16'd7, "R3 load after branch");
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        t_reset();
        t_load();
        t_alu();
        t_ysel();
        t_ignored();
        t_dest();
        t_branch();
        summary();
    end
endmodule